// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Receiver

This block is the digital front end of a two-channel converter. A host sends 24-bit command words over a three-wire serial link. The wires are an active-low frame select, a serial clock and a data line. The block moves each word into a pair of double-buffered channel registers. Every channel has an input (staging) register and an output register, and the output register drives the converter. The two output codes leave the block as parallel buses.

All serial and control pins are sampled by a fast system clock through two-flop synchronizers. Their edges are detected in that clock domain. A frame state machine counts falling serial-clock edges and hands over a complete word. A register bank then decodes the word.

The register bank moves staging values into the output registers in one of three ways:
- at the end of a frame, when the load pin is held low (synchronous mode);
- at the end of a frame, when the command asks for an update;
- for both channels together, on a falling edge of the load pin (asynchronous mode).

A falling edge on the clear pin presets every register to zero scale or mid-scale. A frame in progress at that moment is aborted.

Frame state machine:
- States: `ST_IDLE` (frame select high), `ST_SHIFT` (shifting and counting) and `ST_DRAIN` (waiting for frame select to rise).
- Transitions: `ST_IDLE`→`ST_SHIFT` when frame select is low. `ST_SHIFT`→`ST_IDLE` on an early release of frame select (abort). `ST_SHIFT`→`ST_DRAIN` on the 24th falling edge (word done) or on a clear edge (abort). `ST_DRAIN`→`ST_IDLE` when frame select is high.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, both output codes equal the preset: 0x0000 when MID_SCALE=0, and 0x8000 when MID_SCALE=1.
- R2: A word is sampled MSB first, one bit on each falling edge of `sclk` while `frame_n` is low. Bits [23:22] are ignored, bits [21:19] are the command, bits [18:16] are the channel (0 = A, 1 = B, 7 = both) and bits [15:0] are the data. A completed write is visible on the outputs within 4 system clocks of the 24th falling edge.
- R3: If `frame_n` rises before the 24th falling edge, the frame is discarded and no register changes.
- R4: Falling edges after the 24th are ignored until `frame_n` returns high.
- R5: Command 1 writes the data to the staging register and the output register of the addressed channel(s).
- R6: Command 0 with `load_n` high writes only the staging register; the output codes do not change.
- R7: Command 0 with `load_n` held low also writes the addressed output register (synchronous mode).
- R8: A falling edge on `load_n` copies both staging registers to both output registers at the same time.
- R9: Command 2 copies the staging register of the addressed channel(s) to the output register and ignores the data field.
- R10: A falling edge on `clr_n` presets all four registers, and the preset stays in place until the next completed write.
- R11: A falling edge on `clr_n` during a frame aborts that frame.
- R12: Channel codes 2 to 6 and commands 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data sampled on falling edges |
| sdin | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load strobe: held low for synchronous mode, falling edge for a simultaneous update |
| clr_n | input | 1 | Clear; falling edge presets all registers |
| code_a | output | DATA_W | Output register of channel A |
| code_b | output | DATA_W | Output register of channel B |

## Verification
An edge counter that is off by one, or that misses an abort, shows up in the next frame as a code that is shifted by one bit or written to the wrong channel. This appears on `code_a`/`code_b` within 4 system clocks of the 24th falling edge.

A staging register that is lost or corrupted stays invisible until a later load edge or update command exposes it. For that reason the directed sequence always follows a staging write with a load edge or a command 2 and checks the result.

A clear edge that leaves the frame machine running would produce a stray write after the clear. This is caught by checking that the outputs still hold the preset once the remaining serial edges of the aborted frame have been sent.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int WORD_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DRAIN
    } frame_st_e;

    localparam logic [2:0] CMD_WR_IN  = 3'd0;
    localparam logic [2:0] CMD_WR_UPD = 3'd1;
    localparam logic [2:0] CMD_UPD    = 3'd2;

    localparam logic [2:0] CH_A    = 3'd0;
    localparam logic [2:0] CH_B    = 3'd1;
    localparam logic [2:0] CH_BOTH = 3'd7;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign lvl[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/dacif_frame.sv
module dacif_frame
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl,
    input  logic              sclk_lvl,
    input  logic              clr_lvl,
    input  logic              din,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    frame_st_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             sclk_prev, clr_prev;
    logic             sclk_fall, clr_fall, last_edge;

    assign sclk_fall = sclk_prev & ~sclk_lvl;
    assign clr_fall  = clr_prev & ~clr_lvl;
    assign last_edge = (state == ST_SHIFT) && !sel_lvl && !clr_fall && sclk_fall && (cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!sel_lvl && !clr_fall) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_lvl)        state_nx = ST_IDLE;
                else if (clr_fall)  state_nx = ST_DRAIN;
                else if (last_edge) state_nx = ST_DRAIN;
            end
            ST_DRAIN: if (sel_lvl) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            word      <= '0;
            word_done <= 1'b0;
            sclk_prev <= 1'b1;
            clr_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl;
            clr_prev  <= clr_lvl;
            word_done <= last_edge;
            if (state != ST_SHIFT || sel_lvl) begin
                cnt <= '0;
            end else if (sclk_fall && !clr_fall) begin
                word <= {word[WORD_W-2:0], din};
                if (cnt != LAST) cnt <= cnt + 1'b1;
            end
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);
    a_r11_clear_kills_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall && state == ST_SHIFT) |=> !word_done);
    a_r3_release_kills_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sel_lvl) |=> !word_done);
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter bit MID_SCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              load_lvl,
    input  logic              clr_lvl,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);
    localparam logic [DATA_W-1:0] PRESET = MID_SCALE ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

    logic [DATA_W-1:0] in_a, in_b, data;
    logic [2:0]        cmd, chan;
    logic              hit_a, hit_b, load_prev, clr_prev, load_fall, clr_fall;

    assign cmd       = word[21:19];
    assign chan      = word[18:16];
    assign data      = word[15 -: DATA_W];
    assign hit_a     = (chan == CH_A) || (chan == CH_BOTH);
    assign hit_b     = (chan == CH_B) || (chan == CH_BOTH);
    assign load_fall = load_prev & ~load_lvl;
    assign clr_fall  = clr_prev & ~clr_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_a <= PRESET; in_b <= PRESET;
            out_a <= PRESET; out_b <= PRESET;
            load_prev <= 1'b1; clr_prev <= 1'b1;
        end else begin
            load_prev <= load_lvl;
            clr_prev  <= clr_lvl;
            if (clr_fall) begin
                in_a <= PRESET; in_b <= PRESET;
                out_a <= PRESET; out_b <= PRESET;
            end else if (word_done) begin
                case (cmd)
                    CMD_WR_IN: begin
                        if (hit_a) in_a <= data;
                        if (hit_b) in_b <= data;
                        if (hit_a && !load_lvl) out_a <= data;
                        if (hit_b && !load_lvl) out_b <= data;
                    end
                    CMD_WR_UPD: begin
                        if (hit_a) begin in_a <= data; out_a <= data; end
                        if (hit_b) begin in_b <= data; out_b <= data; end
                    end
                    CMD_UPD: begin
                        if (hit_a) out_a <= in_a;
                        if (hit_b) out_b <= in_b;
                    end
                    default: ;
                endcase
            end else if (load_fall) begin
                out_a <= in_a;
                out_b <= in_b;
            end
        end
    end

    a_r10_clear_preset: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (out_a == PRESET && out_b == PRESET && in_a == PRESET && in_b == PRESET));
    a_r6_staging_only: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !clr_fall && load_lvl && cmd == CMD_WR_IN) |=> ($stable(out_a) && $stable(out_b)));
    a_r12_bad_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !clr_fall && !hit_a && !hit_b) |=>
        ($stable(out_a) && $stable(out_b) && $stable(in_a) && $stable(in_b)));
    a_r8_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && !word_done && !clr_fall) |=> (out_a == $past(in_a) && out_b == $past(in_b)));
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
    parameter int DATA_W      = 16,
    parameter bit MID_SCALE   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              load_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b
);
    logic [4:0]                       lvl;
    logic                             word_done;
    logic [dacif_pkg::WORD_W-1:0]     word;

    dacif_sync #(.N(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sdin, clr_n, load_n, sclk, frame_n}),
        .lvl   (lvl)
    );

    dacif_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_lvl   (lvl[0]),
        .sclk_lvl  (lvl[1]),
        .clr_lvl   (lvl[3]),
        .din       (lvl[4]),
        .word_done (word_done),
        .word      (word)
    );

    dacif_regs #(.DATA_W(DATA_W), .MID_SCALE(MID_SCALE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .load_lvl  (lvl[2]),
        .clr_lvl   (lvl[3]),
        .out_a     (code_a),
        .out_b     (code_b)
    );
endmodule

// File: tb/dual_dac_serial_if_bench.sv
module dual_dac_serial_if_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_n = 1'b1, sclk = 1'b1, sdin = 1'b1, load_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_a, code_b, mid_a, mid_b;
    int n_checks = 0, n_fail = 0;
    logic [15:0] ea = 16'h0, eb = 16'h0;

    always #2.5 clk = ~clk;

    dual_dac_serial_if u_dual_dac_serial_if (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdin(sdin),
        .load_n(load_n), .clr_n(clr_n), .code_a(code_a), .code_b(code_b));

    dual_dac_serial_if #(.MID_SCALE(1'b1)) u_dual_dac_serial_if_mid (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdin(sdin),
        .load_n(load_n), .clr_n(clr_n), .code_a(mid_a), .code_b(mid_b));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_both(input string req);
        check(req, code_a, ea);
        check(req, code_b, eb);
    endtask

    function automatic logic [23:0] mk(input logic [2:0] cmd, input logic [2:0] ch, input logic [15:0] d);
        return {2'b11, cmd, ch, d};
    endfunction

    // nedge falling edges; clear pulse after edge clr_at (negative: none)
    task automatic send(input logic [23:0] w, input int nedge, input int clr_at);
        frame_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nedge; i++) begin
            sdin = (i < 24) ? w[23-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            if (i == clr_at) begin
                clr_n = 1'b0; wait_clk(4); clr_n = 1'b1;
            end
        end
        wait_clk(4);
        frame_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic pulse_load();
        load_n = 1'b0; wait_clk(8); load_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_reset();
        check_both("R1 reset zero preset");
        check("R1 reset mid preset A", mid_a, 16'h8000);
        check("R1 reset mid preset B", mid_b, 16'h8000);
    endtask

    task automatic t_write_update();
        send(mk(3'd1, 3'd0, 16'h1234), 24, -1);
        ea = 16'h1234;
        check_both("R5 write+update A");
    endtask

    task automatic t_async();
        send(mk(3'd0, 3'd1, 16'hBEEF), 24, -1);
        check_both("R6 staging write leaves outputs");
        pulse_load();
        eb = 16'hBEEF;
        check_both("R8 load edge copies both");
    endtask

    task automatic t_sync();
        load_n = 1'b0; wait_clk(8);
        send(mk(3'd0, 3'd0, 16'h5555), 24, -1);
        ea = 16'h5555;
        check_both("R7 sync mode output write");
        load_n = 1'b1; wait_clk(8);
        check_both("R7 load release no change");
    endtask

    task automatic t_abort();
        send(mk(3'd1, 3'd0, 16'hFFFF), 20, -1);
        check_both("R3 early release discards");
        send(mk(3'd1, 3'd1, 16'h1111), 27, -1);
        eb = 16'h1111;
        check_both("R4 extra edges ignored");
    endtask

    task automatic t_update_cmd();
        send(mk(3'd0, 3'd7, 16'h0A0A), 24, -1);
        check_both("R6 staging both, outputs hold");
        send(mk(3'd2, 3'd1, 16'hDEAD), 24, -1);
        eb = 16'h0A0A;
        check_both("R9 update B from staging");
        send(mk(3'd2, 3'd0, 16'h0000), 24, -1);
        ea = 16'h0A0A;
        check_both("R9 update A from staging");
    endtask

    task automatic t_invalid();
        send(mk(3'd1, 3'd3, 16'h2222), 24, -1);
        check_both("R12 channel 3 ignored");
        send(mk(3'd5, 3'd0, 16'h3333), 24, -1);
        check_both("R12 command 5 ignored");
        pulse_load();
        check_both("R12 staging untouched");
    endtask

    task automatic t_clear();
        clr_n = 1'b0; wait_clk(8); clr_n = 1'b1; wait_clk(8);
        ea = 16'h0; eb = 16'h0;
        check_both("R10 clear zero preset");
        check("R10 clear mid A", mid_a, 16'h8000);
        check("R10 clear mid B", mid_b, 16'h8000);
        pulse_load();
        check_both("R10 preset persists over load edge");
    endtask

    task automatic t_clear_in_frame();
        send(mk(3'd1, 3'd0, 16'h4321), 24, 10);
        check_both("R11 clear aborts frame");
        check("R11 mid A preset", mid_a, 16'h8000);
        send(mk(3'd1, 3'd7, 16'h6789), 24, -1);
        ea = 16'h6789; eb = 16'h6789;
        check_both("R2 both channels after clear");
        check("R10 mid leaves clear on write", mid_b, 16'h6789);
    endtask

    initial begin : watchdog
        wait_clk(150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_update();
        t_async();
        t_sync();
        t_abort();
        t_update_cmd();
        t_invalid();
        t_clear();
        t_clear_in_frame();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule